// File: doc/BRIEF.md
# Memory Stick parallel host controller

This block lets a processor run transfers to a removable flash card over a 4-bit parallel data bus. The card side sees a card clock derived from the system clock, a bus-state strobe that marks the phase of the transfer, and four data lines. The data lines are split into an output nibble with an enable and an input nibble. The processor side is a 16-bit port. A chip select and a 2-bit register address pick one access per clock cycle: command write, data read or data write.

Writing a command word starts a transfer and drops a ready flag. The word holds a 4-bit protocol code and a byte count. The transfer runs through four phases: idle, command, a third phase and a fourth phase. What the third and fourth phases carry depends on the direction bit of the code. In a read, status comes first and then card data. In a write, host data comes first and then status.

Data moves one 16-bit word at a time. Each word is handed over through a full or empty flag that the host must acknowledge. Until it does, the card clock is parked low. When the transfer is over, the ready flag goes high again and serves as an end-of-transfer interrupt.

Top module: `msh_ctrl`

## Requirements
- R1: While a transfer is running and not stalled, `sclk` repeats two system cycles low then two high (one quarter of the system clock). It stays low in idle and while either handshake flag is set.
- R2: While `rst` is high on a clock edge, the block returns to idle. In that state `ms_ready`=1, `rd_valid`=0, `wr_empty`=0, `sclk`=0, `bs`=0 and `ms_doe`=0.
- R3: With `ms_ready`=1, a cycle with `cs_n`=0 and `reg_addr`=01 starts a transfer at that clock edge. The command word holds the protocol code in bits 15:12 and the byte count in bits 9:0; bits 11:10 are ignored. At that edge `ms_ready` falls. The command phase then lasts one card clock period with `bs`=1, `ms_doe`=1 and the code on `ms_dout`.
- R4: A command write while `ms_ready`=0 is ignored. The running transfer goes on unchanged.
- R5: `bs` is 0 in idle, 1 in the command phase, 0 in the third phase and 1 in the fourth phase. It changes only where `sclk` falls.
- R6: Code bit 3 = 0 selects a read. In the third phase the card drives status, and the block samples it at each rising `sclk` edge. That phase repeats until a status nibble with bit 0 = 1 (ready) arrives. The fourth phase then samples 2×count nibbles with the high nibble of each byte first. Each word is packed with its first byte in bits 15:8. An odd count leaves bits 7:0 of the last word at 0.
- R7: In a read, `rd_valid` rises after each word and `sclk` stays low until a cycle with `host_ack`=1. While `cs_n`=0 and `reg_addr`=10, `host_rdata` shows the word; at any other time it is 0.
- R8: Code bit 3 = 1 selects a write. Before each word, `wr_empty` rises and `sclk` stays low. A cycle with `cs_n`=0 and `reg_addr`=11 loads the data register. On `host_ack` that word is sent in the third phase with `ms_doe`=1, as 2×count nibbles in total, high nibble first. Each nibble changes only where `sclk` falls.
- R9: In a write, the fourth phase samples status at each rising `sclk` edge until a nibble with bit 0 = 1 arrives. The block then returns to idle.
- R10: At the end of every transfer `ms_ready` returns to 1, with `bs`=0 and both flags at 0.
- R11: A cycle with `cs_n`=0 and `reg_addr`=00 has no effect.
- R12: A byte count of 0 skips the data phase. A read ends after the status phase. A write goes from the command phase straight to the status phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select for the host port, active low, one access per cycle |
| reg_addr | input | 2 | Host register address |
| host_wdata | input | 16 | Host write data (command or data word) |
| host_rdata | output | 16 | Read word while selected with address 10, otherwise 0 |
| rd_valid | output | 1 | Read word waiting for the host |
| wr_empty | output | 1 | Write register waiting for the host |
| host_ack | input | 1 | Host acknowledge of either flag |
| ms_ready | output | 1 | High when idle; low during a transfer |
| sclk | output | 1 | Card clock |
| bs | output | 1 | Bus-state strobe |
| ms_dout | output | 4 | Nibble driven to the card |
| ms_doe | output | 1 | Output enable for the data lines |
| ms_din | input | 4 | Nibble driven by the card |

## Verification
The bench sweeps both directions over byte counts 0, 1, 2, 3 and 5, each with 0 and 2 busy status nibbles before ready. Odd and even counts test the packing of the partial last word. Count 0 tests that the data phase is skipped. The busy values test the status polling loop, because they change the slot count of exactly one phase. A bench-side card model records `bs`, `ms_doe` and `ms_dout` at every rising card clock edge and compares them slot by slot with the phase plan for that count and direction. Each read word is compared with nibbles generated from a seed, and each write nibble with the word the host loaded. In read transfers the bench also issues a command write while the block is busy and checks the clock waveform around it.

// File: rtl/msh_pkg.sv
package msh_pkg;

    localparam int DATA_W        = 16;
    localparam int NIB_W         = 4;
    localparam int NIBS_PER_WORD = DATA_W / NIB_W;
    localparam int WNIB_W        = $clog2(NIBS_PER_WORD);
    localparam int CODE_W        = 4;
    localparam int CODE_LSB      = 12;
    localparam int COUNT_W       = 10;
    localparam int NLEFT_W       = COUNT_W + 1;
    localparam int DIR_BIT       = 3;
    localparam int READY_BIT     = 0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_MID  = 2'd2,
        PH_END  = 2'd3
    } msh_phase_e;

    typedef enum logic [1:0] {
        RA_NONE  = 2'b00,
        RA_CMD   = 2'b01,
        RA_RDATA = 2'b10,
        RA_WDATA = 2'b11
    } msh_raddr_e;

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic [NLEFT_W-1:0] nib_total;
    } msh_cmd_t;

    typedef struct packed {
        logic cmd_wr;
        logic data_wr;
        logic rd_sel;
    } msh_host_req_t;

    function automatic logic phase_bs(msh_phase_e ph);
        return (ph == PH_CMD) || (ph == PH_END);
    endfunction

    function automatic msh_cmd_t unpack_cmd(logic [DATA_W-1:0] w);
        msh_cmd_t c;
        c.code      = w[CODE_LSB +: CODE_W];
        c.nib_total = {w[COUNT_W-1:0], 1'b0};
        return c;
    endfunction

    function automatic logic code_is_write(logic [CODE_W-1:0] c);
        return c[DIR_BIT];
    endfunction

    function automatic logic [DATA_W-1:0] align_word(logic [DATA_W-1:0] w,
                                                     logic [WNIB_W-1:0] last_idx);
        return w << (NIB_W * (NIBS_PER_WORD - 1 - int'(last_idx)));
    endfunction

endpackage

// File: rtl/msh_sclk_gen.sv
module msh_sclk_gen #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic samp_tick,
    output logic end_tick
);
    localparam logic [DIV_LOG2-1:0] SAMP_AT = (DIV_LOG2)'((1 << (DIV_LOG2 - 1)) - 1);
    localparam logic [DIV_LOG2-1:0] END_AT  = '1;

    logic [DIV_LOG2-1:0] phase_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_cnt <= '0;
        end else if (run) begin
            phase_cnt <= phase_cnt + 1'b1;
        end
    end

    always_comb begin
        sclk      = phase_cnt[DIV_LOG2-1];
        samp_tick = run && (phase_cnt == SAMP_AT);
        end_tick  = run && (phase_cnt == END_AT);
    end
endmodule

// File: rtl/msh_host_port.sv
module msh_host_port
    import msh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] rd_word,
    output msh_host_req_t     req,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] host_rdata
);
    always_comb begin
        req.cmd_wr  = !cs_n && (reg_addr == RA_CMD);
        req.data_wr = !cs_n && (reg_addr == RA_WDATA);
        req.rd_sel  = !cs_n && (reg_addr == RA_RDATA);
        host_rdata  = req.rd_sel ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (req.data_wr) begin
            wdata_q <= host_wdata;
        end
    end
endmodule

// File: rtl/msh_xfer_fsm.sv
module msh_xfer_fsm
    import msh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_word,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              host_ack,
    input  logic              samp_tick,
    input  logic              end_tick,
    input  logic [NIB_W-1:0]  ms_din,
    output msh_phase_e        phase,
    output logic              ms_ready,
    output logic              rd_valid,
    output logic              wr_empty,
    output logic [DATA_W-1:0] rd_word,
    output logic [NIB_W-1:0]  ms_dout,
    output logic              ms_doe,
    output logic              run
);
    logic               dir_wr;
    logic [NLEFT_W-1:0] nib_left;
    logic [WNIB_W-1:0]  word_nib;
    logic [DATA_W-1:0]  shift_q;
    logic [NIB_W-1:0]   samp;
    msh_cmd_t           cmd_in;
    logic [DATA_W-1:0]  asm_w;
    logic               last_nib;
    logic               word_full;
    logic               status_ok;

    always_comb begin
        cmd_in    = unpack_cmd(cmd_word);
        asm_w     = {shift_q[DATA_W-NIB_W-1:0], samp};
        last_nib  = (nib_left == NLEFT_W'(1));
        word_full = (word_nib == WNIB_W'(NIBS_PER_WORD - 1));
        status_ok = samp[READY_BIT];
        run       = (phase != PH_IDLE) && !rd_valid && !wr_empty;
    end

    // card nibble captured where the card clock rises
    always_ff @(posedge clk) begin
        if (rst) begin
            samp <= '0;
        end else if (samp_tick) begin
            samp <= ms_din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            ms_ready <= 1'b1;
            rd_valid <= 1'b0;
            wr_empty <= 1'b0;
            rd_word  <= '0;
            ms_dout  <= '0;
            ms_doe   <= 1'b0;
            dir_wr   <= 1'b0;
            nib_left <= '0;
            word_nib <= '0;
            shift_q  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (cmd_wr) begin
                        phase    <= PH_CMD;
                        ms_ready <= 1'b0;
                        dir_wr   <= code_is_write(cmd_in.code);
                        nib_left <= cmd_in.nib_total;
                        ms_dout  <= cmd_in.code;
                        ms_doe   <= 1'b1;
                        word_nib <= '0;
                        shift_q  <= '0;
                    end
                end
                PH_CMD: begin
                    if (end_tick) begin
                        if (!dir_wr) begin
                            phase  <= PH_MID;
                            ms_doe <= 1'b0;
                        end else if (nib_left == '0) begin
                            phase  <= PH_END;
                            ms_doe <= 1'b0;
                        end else begin
                            phase    <= PH_MID;
                            wr_empty <= 1'b1;
                        end
                    end
                end
                PH_MID: begin
                    if (dir_wr) begin
                        if (wr_empty) begin
                            if (host_ack) begin
                                wr_empty <= 1'b0;
                                ms_dout  <= wdata_q[DATA_W-1 -: NIB_W];
                                shift_q  <= wdata_q << NIB_W;
                                word_nib <= '0;
                            end
                        end else if (end_tick) begin
                            nib_left <= nib_left - 1'b1;
                            if (last_nib) begin
                                phase  <= PH_END;
                                ms_doe <= 1'b0;
                            end else if (word_full) begin
                                wr_empty <= 1'b1;
                                word_nib <= '0;
                            end else begin
                                word_nib <= word_nib + 1'b1;
                                ms_dout  <= shift_q[DATA_W-1 -: NIB_W];
                                shift_q  <= shift_q << NIB_W;
                            end
                        end
                    end else if (end_tick && status_ok) begin
                        word_nib <= '0;
                        shift_q  <= '0;
                        if (nib_left == '0) begin
                            phase    <= PH_IDLE;
                            ms_ready <= 1'b1;
                        end else begin
                            phase <= PH_END;
                        end
                    end
                end
                PH_END: begin
                    if (dir_wr) begin
                        if (end_tick && status_ok) begin
                            phase    <= PH_IDLE;
                            ms_ready <= 1'b1;
                        end
                    end else if (rd_valid) begin
                        if (host_ack) begin
                            rd_valid <= 1'b0;
                            if (nib_left == '0) begin
                                phase    <= PH_IDLE;
                                ms_ready <= 1'b1;
                            end
                        end
                    end else if (end_tick) begin
                        nib_left <= nib_left - 1'b1;
                        if (last_nib || word_full) begin
                            rd_word  <= align_word(asm_w, word_nib);
                            rd_valid <= 1'b1;
                            word_nib <= '0;
                            shift_q  <= '0;
                        end else begin
                            shift_q  <= asm_w;
                            word_nib <= word_nib + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/msh_ctrl.sv
module msh_ctrl
    import msh_pkg::*;
#(
    parameter int DIV_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rd_valid,
    output logic              wr_empty,
    input  logic              host_ack,
    output logic              ms_ready,
    output logic              sclk,
    output logic              bs,
    output logic [NIB_W-1:0]  ms_dout,
    output logic              ms_doe,
    input  logic [NIB_W-1:0]  ms_din
);
    msh_host_req_t     req;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_word;
    msh_phase_e        phase;
    logic              run;
    logic              samp_tick;
    logic              end_tick;

    msh_host_port u_port (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .reg_addr   (reg_addr),
        .host_wdata (host_wdata),
        .rd_word    (rd_word),
        .req        (req),
        .wdata_q    (wdata_q),
        .host_rdata (host_rdata)
    );

    msh_sclk_gen #(.DIV_LOG2(DIV_LOG2)) u_sclk (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .sclk      (sclk),
        .samp_tick (samp_tick),
        .end_tick  (end_tick)
    );

    msh_xfer_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (req.cmd_wr),
        .cmd_word  (host_wdata),
        .wdata_q   (wdata_q),
        .host_ack  (host_ack),
        .samp_tick (samp_tick),
        .end_tick  (end_tick),
        .ms_din    (ms_din),
        .phase     (phase),
        .ms_ready  (ms_ready),
        .rd_valid  (rd_valid),
        .wr_empty  (wr_empty),
        .rd_word   (rd_word),
        .ms_dout   (ms_dout),
        .ms_doe    (ms_doe),
        .run       (run)
    );

    assign bs = phase_bs(phase);
endmodule

// File: rtl/msh_ctrl_chk.sv
module msh_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ms_ready,
    input logic       rd_valid,
    input logic       wr_empty,
    input logic       sclk,
    input logic       bs,
    input logic       ms_doe,
    input logic [3:0] ms_dout
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ms_ready |-> (!sclk && !bs && !ms_doe)); // R5

    AST_STALL_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        (rd_valid || wr_empty) |-> !sclk); // R7

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_valid && wr_empty)); // R8

    AST_READY_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        ms_ready |-> (!rd_valid && !wr_empty)); // R10

    AST_START_CMD_PHASE: assert property (@(posedge clk) disable iff (rst)
        $fell(ms_ready) |-> (bs && ms_doe)); // R3

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        sclk |-> ($stable(ms_dout) && $stable(bs))); // R5

    AST_SCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |=> sclk); // R1

    AST_SCLK_LOW_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |=> !sclk); // R1
endmodule

bind msh_ctrl msh_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ms_ready (ms_ready),
    .rd_valid (rd_valid),
    .wr_empty (wr_empty),
    .sclk     (sclk),
    .bs       (bs),
    .ms_doe   (ms_doe),
    .ms_dout  (ms_dout)
);

// File: tb/msh_ctrl_bench.sv
`timescale 1ns/1ps
module msh_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic [1:0]  reg_addr = 2'b00;
    logic [15:0] host_wdata = 16'h0;
    logic        host_ack = 1'b0;
    logic [15:0] host_rdata;
    logic        rd_valid, wr_empty, ms_ready, sclk, bs, ms_doe;
    logic [3:0]  ms_dout;
    logic [3:0]  ms_din;

    always #10 clk = ~clk;

    msh_ctrl u_msh_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .reg_addr(reg_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .rd_valid(rd_valid), .wr_empty(wr_empty), .host_ack(host_ack),
        .ms_ready(ms_ready), .sclk(sclk), .bs(bs),
        .ms_dout(ms_dout), .ms_doe(ms_doe), .ms_din(ms_din)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int txn_id = 0;
    bit cfg_wr = 1'b0;
    int cfg_busy = 0;
    int cfg_seed = 0;

    logic       rec_bs  [64];
    logic       rec_doe [64];
    logic [3:0] rec_dout[64];
    int         rec_n = 0;

    function automatic logic [3:0] rd_nib(int seed, int k);
        return 4'((k * 5 + seed) & 15);
    endfunction

    function automatic logic [15:0] wr_word(int seed, int j);
        return 16'(((j + 1) * 14961 + seed * 257) & 16'hFFFF);
    endfunction

    function automatic logic [15:0] exp_rd_word(int seed, int j, int cnt);
        logic [15:0] w = 16'h0;
        for (int q = 0; q < 4; q++) begin
            int k = 4 * j + q;
            w = {w[11:0], (k < 2 * cnt) ? rd_nib(seed, k) : 4'h0};
        end
        return w;
    endfunction

    function automatic logic [3:0] exp_wr_nib(int seed, int k);
        logic [15:0] w = wr_word(seed, k / 4);
        return 4'(w >> (4 * (3 - (k % 4))));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp,
                       input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // slot recorder: values seen by the card at each rising card clock edge
    initial begin
        int seen = 0;
        forever begin
            @(posedge sclk);
            if (seen != txn_id) begin
                seen  = txn_id;
                rec_n = 0;
            end
            if (rec_n < 64) begin
                rec_bs[rec_n]   = bs;
                rec_doe[rec_n]  = ms_doe;
                rec_dout[rec_n] = ms_dout;
            end
            rec_n++;
        end
    end

    // card model: drives a new nibble just after each falling card clock edge
    initial begin
        int seen = 0;
        int nib = 0;
        int st = 0;
        ms_din = 4'h0;
        forever begin
            @(negedge sclk);
            #1;
            if (seen != txn_id) begin
                seen = txn_id;
                nib  = 0;
                st   = 0;
            end
            if (!ms_ready) begin
                if (!cfg_wr && !bs) begin
                    ms_din = (st < cfg_busy) ? 4'h0 : 4'h1;
                    st++;
                end else if (!cfg_wr && bs) begin
                    ms_din = rd_nib(cfg_seed, nib);
                    nib++;
                end else if (cfg_wr && bs) begin
                    ms_din = (st < cfg_busy) ? 4'hE : 4'h1;
                    st++;
                end
            end
        end
    end

    task automatic run_txn(input bit wr, input int cnt, input int busy, input int seed);
        logic [3:0]  code;
        logic [7:0]  pat;
        int          nw;
        int          total;
        int          bs_bad;
        int          dat_bad;
        int          bad_slot;
        string       tot_req;
        cfg_wr   = wr;
        cfg_busy = busy;
        cfg_seed = seed;
        txn_id++;
        code = {wr, 3'(seed)};
        cs_n = 1'b0;
        reg_addr = 2'b01;
        host_wdata = {code, 2'b11, 10'(cnt)};
        @(negedge clk);
        cs_n = 1'b1;
        chk({ms_ready, bs, ms_doe, ms_dout} == {3'b011, code}, "R3",
            {ms_ready, bs, ms_doe, ms_dout}, {3'b011, code}, "start state");
        if (!wr) begin
            pat = 8'h0;
            pat[0] = sclk;
            for (int i = 1; i < 8; i++) begin
                if (i == 2) begin
                    cs_n = 1'b0;
                    reg_addr = 2'b01;
                    host_wdata = {~code, 2'b00, 10'd7};
                end
                if (i == 3) cs_n = 1'b1;
                @(negedge clk);
                pat[i] = sclk;
            end
            chk(pat == 8'b1100_1100, "R1", pat, 8'b1100_1100, "sclk pattern");
        end
        nw = (cnt + 1) / 2;
        for (int j = 0; j < nw; j++) begin
            bit stalled = 1'b1;
            if (!wr) begin
                while (!rd_valid) @(negedge clk);
                repeat (3) begin
                    @(negedge clk);
                    if (sclk) stalled = 1'b0;
                end
                chk(stalled && rd_valid, "R7", {stalled, rd_valid}, 2'b11, "read stall");
                chk(host_rdata == 16'h0, "R7", host_rdata, 0, "rdata unselected");
                cs_n = 1'b0;
                reg_addr = 2'b10;
                #1;
                chk(host_rdata == exp_rd_word(seed, j, cnt), "R6", host_rdata,
                    exp_rd_word(seed, j, cnt), "read word");
                host_ack = 1'b1;
                @(negedge clk);
                host_ack = 1'b0;
                cs_n = 1'b1;
            end else begin
                while (!wr_empty) @(negedge clk);
                repeat (3) begin
                    @(negedge clk);
                    if (sclk) stalled = 1'b0;
                end
                chk(stalled && wr_empty, "R8", {stalled, wr_empty}, 2'b11, "write stall");
                cs_n = 1'b0;
                reg_addr = 2'b11;
                host_wdata = wr_word(seed, j);
                @(negedge clk);
                cs_n = 1'b1;
                host_ack = 1'b1;
                @(negedge clk);
                host_ack = 1'b0;
            end
        end
        while (!ms_ready) @(negedge clk);
        chk({bs, rd_valid, wr_empty, sclk, ms_doe} == 5'b0, "R10",
            {bs, rd_valid, wr_empty, sclk, ms_doe}, 0, "end state");
        total = 2 + busy + 2 * cnt;
        tot_req = (cnt == 0) ? "R12" : (wr ? "R9" : "R6");
        chk(rec_n == total, tot_req, rec_n, total, "slot count");
        if (!wr) chk(rec_n == total, "R4", rec_n, total, "slots after rejected cmd");
        bs_bad = 0;
        dat_bad = 0;
        bad_slot = -1;
        for (int s = 0; s < total && s < 64; s++) begin
            bit e_bs;
            bit e_doe;
            logic [3:0] e_dout;
            e_dout = 4'h0;
            if (s == 0) begin
                e_bs = 1'b1; e_doe = 1'b1; e_dout = code;
            end else if (!wr) begin
                e_bs = (s > busy + 1); e_doe = 1'b0;
            end else if (s <= 2 * cnt) begin
                e_bs = 1'b0; e_doe = 1'b1; e_dout = exp_wr_nib(seed, s - 1);
            end else begin
                e_bs = 1'b1; e_doe = 1'b0;
            end
            if (rec_bs[s] !== e_bs) bs_bad++;
            if (rec_doe[s] !== e_doe || (e_doe && rec_dout[s] !== e_dout)) begin
                dat_bad++;
                if (bad_slot < 0) bad_slot = s;
            end
        end
        chk(bs_bad == 0, "R5", bs_bad, 0, "bs level mismatches");
        chk(dat_bad == 0, wr ? "R8" : "R3", bad_slot, -1, "first bad data slot");
    endtask

    initial begin
        int cnts[5] = '{0, 1, 2, 3, 5};
        int seed = 1;
        bit quiet;
        repeat (3) @(negedge clk);
        chk({ms_ready, rd_valid, wr_empty, sclk, bs, ms_doe} == 6'b100000, "R2",
            {ms_ready, rd_valid, wr_empty, sclk, bs, ms_doe}, 6'b100000, "reset state");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;
        reg_addr = 2'b00;
        host_wdata = 16'h8005;
        @(negedge clk);
        cs_n = 1'b1;
        quiet = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (!ms_ready || sclk || bs || rd_valid || wr_empty) quiet = 1'b0;
        end
        chk(quiet, "R11", quiet, 1, "no-op access");
        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c < 5; c++) begin
                for (int b = 0; b <= 2; b += 2) begin
                    run_txn(d[0], cnts[c], b, seed);
                    seed += 3;
                    repeat (2) @(negedge clk);
                end
            end
        end
        quiet = 1'b1;
        repeat (20) begin
            @(negedge clk);
            if (!ms_ready || sclk) quiet = 1'b0;
        end
        chk(quiet, "R10", quiet, 1, "stays idle");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule